// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is an 8-bit watchdog counter that advances on ticks from a programmable power-of-two prescaler. Software reaches it through a small synchronous register port with a write strobe, a read strobe and an address. There are two registers: the count and a control/status register. Every write is 16 bits wide. A write lands only if its upper byte holds the key that belongs to the addressed register, so a stray store cannot reprogram or feed the watchdog. Reads return 8 bits.

When enabled, the counter steps once per prescaler period. It wraps from 0xFF to 0x00. On that wrap it sets a sticky overflow flag and raises a reset request for exactly one clock. Software keeps the system alive by rewriting the count before the wrap. The prescaler period is selected by a 3-bit code, and the prescaler restarts whenever that code changes. While the timer is disabled, both the counter and the prescaler hold their values, so a new count can be preloaded before the timer is started.

Top module: `keyed_wdt`

## Requirements
- R1: A write to address 0 whose upper byte is 0x5A loads the lower byte into the count. If a prescaler tick falls in the same cycle, the write wins.
- R2: A write to address 1 whose upper byte is 0xA5 updates the control/status register from the lower byte. The layout is: bits 2:0 the divide code, bit 5 the enable, bit 7 the overflow flag. All other bits read 0.
- R3: A write whose upper byte does not equal the key of the addressed register changes nothing in that register. This includes using the other register's key.
- R4: A read strobe returns the addressed 8-bit value on `bus_rdata` one clock later. Address 0 returns the count, address 1 the control/status register, and any other address returns 0.
- R5: After reset the count is 0x00 and the control/status register is 0x00 (divide code 0, disabled, flag clear). The reset request is low.
- R6: While enabled, the counter increments once every 32·2^code clocks, where code is 0..7 (ratios 32 up to 4096).
- R7: While disabled, the count and the prescaler hold. A keyed count write still preloads the count.
- R8: The overflow flag sets when the count wraps from 0xFF to 0x00 and stays set. A keyed control write with bit 7 at 0 clears it. Writing 1 to bit 7 never sets it. A wrap wins over a clear in the same cycle.
- R9: `wdt_rst_req` is high for exactly one clock, in the first cycle in which the count reads 0x00 after a wrap.
- R10: A keyed control write that changes the divide code restarts the prescaler from zero, so the next tick comes a full new period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address (0 count, 1 control/status) |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 8 | Registered read data |
| wdt_ovf | output | 1 | Sticky overflow flag |
| wdt_rst_req | output | 1 | One-clock reset request on wrap |

## Verification
The assertions watch several properties on every cycle:
- the prescaler count stays inside the selected period;
- an unloaded tick steps the count by one;
- the count and the control fields hold when disabled or when written with a wrong key;
- the overflow flag stays set until it is cleared;
- the reset request is a single pulse that coincides with a zero count.

The directed scenarios cover what only exact timing can show. They measure the wrap period for several divide codes and preloads, show that a divide-code change restarts the period, and prove through readback that wrong-key writes left the registers untouched. They also walk the flag through its set, no-set and clear writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register addresses
  localparam int unsigned ADDR_CNT = 0;
  localparam int unsigned ADDR_CSR = 1;

  // Write keys carried in the upper byte of a write
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CSR = 8'hA5;

  // Control/status bit positions
  localparam int unsigned CSR_OVF_BIT = 7;
  localparam int unsigned CSR_EN_BIT  = 5;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned PRE_W = BASE_LOG2 + NSEL - 1;

  logic [PRE_W-1:0] term [NSEL];
  logic [PRE_W-1:0] pre_q;
  logic             at_term;

  // Terminal count for each code: 2^(BASE_LOG2+code) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term[g] = {PRE_W{1'b1}} >> (NSEL - 1 - g);
  end

  assign at_term = (pre_q == term[sel]);
  assign tick    = en && !restart && at_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (en) begin
      if (at_term) pre_q <= '0;
      else         pre_q <= pre_q + 1'b1;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_q <= term[sel]);  // R6
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_now,
  output logic             rst_req
);
  assign wrap_now = tick && !load && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap_now;
      if (load)      cnt <= load_val;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);  // R9
  AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (cnt == '0));  // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));  // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));  // R1
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2*REG_W-1:0] wdata,
  input  logic [REG_W-1:0]   cnt,
  input  logic               wrap_now,
  output logic               load,
  output logic [REG_W-1:0]   load_val,
  output logic               en,
  output logic [SEL_W-1:0]   sel,
  output logic               restart,
  output logic               ovf,
  output logic [REG_W-1:0]   rdata
);
  logic [REG_W-1:0] key;
  logic [REG_W-1:0] low;
  logic             addr_cnt;
  logic             addr_csr;
  logic             csr_hit;
  logic [REG_W-1:0] csr_view;

  assign key      = wdata[2*REG_W-1:REG_W];
  assign low      = wdata[REG_W-1:0];
  assign addr_cnt = (addr == ADDR_W'(ADDR_CNT));
  assign addr_csr = (addr == ADDR_W'(ADDR_CSR));

  assign load     = wr && addr_cnt && (key == REG_W'(KEY_CNT));
  assign load_val = low;
  assign csr_hit  = wr && addr_csr && (key == REG_W'(KEY_CSR));
  assign restart  = csr_hit && (low[SEL_W-1:0] != sel);

  always_comb begin
    csr_view              = '0;
    csr_view[CSR_OVF_BIT] = ovf;
    csr_view[CSR_EN_BIT]  = en;
    csr_view[SEL_W-1:0]   = sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      sel <= '0;
      ovf <= 1'b0;
    end else begin
      if (csr_hit) begin
        en  <= low[CSR_EN_BIT];
        sel <= low[SEL_W-1:0];
      end
      if (wrap_now)                          ovf <= 1'b1;
      else if (csr_hit && !low[CSR_OVF_BIT]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (addr_cnt)      rdata <= cnt;
      else if (addr_csr) rdata <= csr_view;
      else               rdata <= '0;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(csr_hit && !low[CSR_OVF_BIT])) |=> ovf);  // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    wrap_now |=> ovf);  // R8
  AST_BADKEY_CSR: assert property (@(posedge clk) disable iff (rst)
    (wr && addr_csr && key != REG_W'(KEY_CSR)) |=> ($stable(en) && $stable(sel)));  // R3
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 5,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [2*REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               wdt_ovf,
  output logic               wdt_rst_req
);
  logic             cnt_load;
  logic [REG_W-1:0] cnt_load_val;
  logic [REG_W-1:0] cnt_val;
  logic             csr_en;
  logic [SEL_W-1:0] csr_sel;
  logic             pre_restart;
  logic             pre_tick;
  logic             wrap_now;

  wdt_regs #(.REG_W(REG_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt_val),
    .wrap_now (wrap_now),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .en       (csr_en),
    .sel      (csr_sel),
    .restart  (pre_restart),
    .ovf      (wdt_ovf),
    .rdata    (bus_rdata)
  );

  wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .en      (csr_en),
    .restart (pre_restart),
    .sel     (csr_sel),
    .tick    (pre_tick)
  );

  wdt_counter #(.CNT_W(REG_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (pre_tick),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .cnt      (cnt_val),
    .wrap_now (wrap_now),
    .rst_req  (wdt_rst_req)
  );

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!csr_en && !cnt_load) |=> $stable(cnt_val));  // R7
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> wdt_ovf);  // R9
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        wdt_ovf;
  logic        wdt_rst_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  keyed_wdt i_keyed_wdt (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_ovf(wdt_ovf), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // Preload and start with a forced divide-code change so the prescaler starts at zero
  task automatic arm(input int code, input logic [7:0] preload);
    bus_write(2'd1, {8'hA5, 5'b0, 3'(code ^ 1)});
    bus_write(2'd0, {8'h5A, preload});
    bus_write(2'd1, {8'hA5, 8'h20 | 8'(code)});
  endtask

  task automatic wait_req(input string req, input int exp_cycles);
    int k = 0;
    while (!wdt_rst_req && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(req, k, exp_cycles);
    @(negedge clk);
    chk("R9 pulse width", int'(wdt_rst_req), 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R5 rst_req", int'(wdt_rst_req), 0);
    chk("R5 ovf", int'(wdt_ovf), 0);
    bus_read(2'd0, v); chk("R5 count", v, 8'h00);
    bus_read(2'd1, v); chk("R5 csr", v, 8'h00);
  endtask

  task automatic t_keys();
    logic [7:0] v;
    bus_write(2'd0, 16'h5A3C);
    bus_read(2'd0, v); chk("R1 keyed count write", v, 8'h3C);
    bus_write(2'd0, 16'hA511);
    bus_read(2'd0, v); chk("R3 csr key on count", v, 8'h3C);
    bus_write(2'd0, 16'h0044);
    bus_read(2'd0, v); chk("R3 zero key on count", v, 8'h3C);
    bus_write(2'd1, 16'hA5FE);
    bus_read(2'd1, v); chk("R2 csr layout", v, 8'h26);
    bus_write(2'd1, 16'h5A01);
    bus_read(2'd1, v); chk("R3 count key on csr", v, 8'h26);
    bus_write(2'd1, 16'hA400);
    bus_read(2'd1, v); chk("R3 near key on csr", v, 8'h26);
    bus_read(2'd2, v); chk("R4 unmapped read", v, 8'h00);
    bus_write(2'd1, 16'hA500);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    int seen = 0;
    bus_write(2'd1, 16'hA500);
    bus_write(2'd0, 16'h5A77);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdt_rst_req) seen++;
    end
    bus_read(2'd0, v); chk("R7 count held", v, 8'h77);
    chk("R7 no request while disabled", seen, 0);
  endtask

  task automatic t_step();
    logic [7:0] v;
    arm(0, 8'h10);
    repeat (100) @(negedge clk);
    bus_read(2'd0, v); chk("R6 three steps at /32", v, 8'h13);
  endtask

  task automatic t_wrap(input int code, input logic [7:0] preload);
    logic [7:0] v;
    arm(code, preload);
    wait_req("R6 wrap period", (32 << code) * (256 - int'(preload)));
    bus_read(2'd0, v); chk("R9 count zero after wrap", v, 8'h00);
    bus_read(2'd1, v); chk("R8 flag set", v, 8'hA0 | 8'(code));
  endtask

  task automatic t_restart();
    arm(0, 8'hFF);
    repeat (19) @(negedge clk);
    bus_write(2'd1, 16'hA521);
    wait_req("R10 restart on code change", 64);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    bus_write(2'd1, 16'hA580);
    bus_read(2'd1, v); chk("R8 write 1 keeps flag", v, 8'h80);
    chk("R8 flag port", int'(wdt_ovf), 1);
    bus_write(2'd1, 16'h0000);
    bus_read(2'd1, v); chk("R8 unkeyed clear ignored", v, 8'h80);
    bus_write(2'd1, 16'hA500);
    bus_read(2'd1, v); chk("R8 keyed clear", v, 8'h00);
    bus_write(2'd1, 16'hA580);
    bus_read(2'd1, v); chk("R8 write 1 cannot set", v, 8'h00);
    chk("R8 flag port clear", int'(wdt_ovf), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_keys();
    t_hold();
    t_step();
    t_wrap(0, 8'hF0);
    t_wrap(1, 8'hFC);
    t_wrap(3, 8'hFE);
    t_wrap(7, 8'hFF);
    t_restart();
    t_flag();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule